// File: doc/BRIEF.md
# Input Capture Unit with Noise Canceler

This block records the value of a free-running 16-bit counter at the moment a chosen edge appears on a trigger input. The trigger can come from an external capture pin or from an internal comparator output. A configuration bit picks which one. A second bit picks whether a rising or a falling transition counts. Both trigger inputs pass through a two-flop synchronizer. The selected level can then go through an optional canceler. The canceler accepts a new level only after four consecutive system-clock samples agree on it.

On each accepted edge, the counter value is written into the capture register and a sticky flag is raised. Software clears the flag by writing a one, which reaches the block as a single-cycle `flag_clr_i` pulse. A later capture overwrites the register whether or not the flag has been cleared.

Changing the source, the polarity or the canceler enable reloads the edge history and the canceler from the newly selected input. A configuration change therefore never produces a capture by itself.

Top module: `icap_unit`

## Requirements
- R1: After reset, `cap_val_o` is 0 and `cap_flag_o` is 0.
- R2: With the canceler off, a qualifying transition of the selected input stores the `count_i` value sampled on the third rising clock edge after the change into `cap_val_o`.
- R3: `edge_sel_i` = 1 captures on a 0-to-1 transition and `edge_sel_i` = 0 captures on a 1-to-0 transition. A transition in the other direction leaves `cap_val_o` and `cap_flag_o` unchanged.
- R4: `src_sel_i` = 0 takes the trigger from `cap_pin_i` and `src_sel_i` = 1 takes it from `cmp_i`. Transitions on the unselected input cause no capture.
- R5: With `filt_en_i` = 1, a new level is accepted only after four consecutive synchronized samples agree. The capture then takes `count_i` from the seventh rising edge after the input change, which is four cycles later than in R2.
- R6: With `filt_en_i` = 1, a pulse on the selected input lasting fewer than four clock cycles causes no capture.
- R7: A capture sets `cap_flag_o`. The flag stays set until a clock edge with `flag_clr_i` = 1. A capture on that same edge keeps the flag set.
- R8: A capture while `cap_flag_o` is still set overwrites `cap_val_o` with the new counter value.
- R9: A change of `src_sel_i`, `edge_sel_i` or `filt_en_i` never causes a capture, either in the cycle of the change or from the stale history it leaves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| count_i | input | 16 | Running counter value |
| cap_pin_i | input | 1 | External capture pin (asynchronous) |
| cmp_i | input | 1 | Internal comparator output (asynchronous) |
| src_sel_i | input | 1 | Trigger source: 0 = pin, 1 = comparator |
| edge_sel_i | input | 1 | Trigger edge: 1 = rising, 0 = falling |
| filt_en_i | input | 1 | Enables the four-sample noise canceler |
| flag_clr_i | input | 1 | Write-one-to-clear pulse for the flag |
| cap_val_o | output | 16 | Captured counter value |
| cap_flag_o | output | 1 | Sticky capture flag |

## Verification
A stale edge history or an unloaded canceler shows up as an unwanted capture: the flag rises a few cycles after a configuration write with no real transition on the input. A miscounted synchronizer or canceler stage shows up at the first capture as a `cap_val_o` that is off by one or more counts. The bench therefore compares the captured value exactly against the counter and checks the flag one cycle before the expected capture. A lost flag update is visible on the first clock edge after the capture or after the clear.

// File: rtl/icap_pkg.sv
package icap_pkg;
  typedef struct packed {
    logic src;   // 0 pin, 1 comparator
    logic pol;   // 1 rising, 0 falling
    logic filt;  // canceler enable
  } icap_cfg_t;

  localparam int unsigned NUM_SRC = 2;
endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ff_q <= '0;
    else         ff_q <= {ff_q[STAGES-2:0], d_i};
  end

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/icap_filter.sv
module icap_filter #(
  parameter int unsigned LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  input  logic load_i,
  output logic lvl_o
);
  // LEN-1 history bits plus the live sample form the agreement window
  logic [LEN-2:0] hist_q;
  logic [LEN-1:0] win;
  logic           lvl_q;
  logic           agree;

  assign win   = {hist_q, d_i};
  assign agree = (&win) | ~(|win);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      lvl_q  <= 1'b0;
    end else if (load_i) begin
      hist_q <= {(LEN-1){d_i}};
      lvl_q  <= d_i;
    end else begin
      hist_q <= win[LEN-2:0];
      if (agree) lvl_q <= d_i;
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/icap_edge.sv
module icap_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic pol_i,
  input  logic reload_i,
  input  logic reload_lvl_i,
  output logic fire_o
);
  logic norm, prev_q;

  // normalize so that a qualifying edge is always 0 -> 1
  assign norm = lvl_i ~^ pol_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       prev_q <= 1'b1;
    else if (reload_i) prev_q <= reload_lvl_i ~^ pol_i;
    else               prev_q <= norm;
  end

  assign fire_o = norm & ~prev_q & ~reload_i;
endmodule

// File: rtl/icap_unit.sv
module icap_unit #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] count_i,
  input  logic             cap_pin_i,
  input  logic             cmp_i,
  input  logic             src_sel_i,
  input  logic             edge_sel_i,
  input  logic             filt_en_i,
  input  logic             flag_clr_i,
  output logic [CNT_W-1:0] cap_val_o,
  output logic             cap_flag_o
);
  import icap_pkg::*;

  logic [NUM_SRC-1:0] raw, synced;
  icap_cfg_t          cfg, cfg_q;
  logic               cfg_vld_q;
  logic               cfg_chg;
  logic               sel_lvl, filt_lvl, det_lvl;
  logic               cap_fire;
  logic [CNT_W-1:0]   val_q;
  logic               flag_q;

  assign raw = {cmp_i, cap_pin_i};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_sync
    icap_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw[i]),
      .q_o   (synced[i])
    );
  end

  assign cfg = '{src: src_sel_i, pol: edge_sel_i, filt: filt_en_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q     <= '0;
      cfg_vld_q <= 1'b0;
    end else begin
      cfg_q     <= cfg;
      cfg_vld_q <= 1'b1;
    end
  end

  // first cycle after reset is treated as a configuration load
  assign cfg_chg = ~cfg_vld_q | (cfg != cfg_q);
  assign sel_lvl = synced[cfg.src];

  icap_filter #(.LEN(FILT_LEN)) u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sel_lvl),
    .load_i(cfg_chg),
    .lvl_o (filt_lvl)
  );

  assign det_lvl = cfg.filt ? filt_lvl : sel_lvl;

  icap_edge u_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lvl_i       (det_lvl),
    .pol_i       (cfg.pol),
    .reload_i    (cfg_chg),
    .reload_lvl_i(sel_lvl),
    .fire_o      (cap_fire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (cap_fire) val_q <= count_i;
      if (cap_fire)        flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
    end
  end

  assign cap_val_o  = val_q;
  assign cap_flag_o = flag_q;
endmodule

// File: rtl/icap_unit_chk.sv
module icap_unit_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             src_sel_i,
  input logic             edge_sel_i,
  input logic             filt_en_i,
  input logic             flag_clr_i,
  input logic             cap_fire,
  input logic [CNT_W-1:0] cap_val_o,
  input logic             cap_flag_o
);
  assert_val_only_on_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cap_val_o) |-> cap_flag_o);

  assert_fire_sets_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_fire |=> cap_flag_o);

  assert_flag_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_flag_o && !flag_clr_i) |=> cap_flag_o);

  assert_flag_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_flag_o && flag_clr_i && !cap_fire) |=> !cap_flag_o);

  assert_cfg_change_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i != $past(src_sel_i) || edge_sel_i != $past(edge_sel_i) ||
     filt_en_i != $past(filt_en_i)) |-> !cap_fire);
endmodule

bind icap_unit icap_unit_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .src_sel_i (src_sel_i),
  .edge_sel_i(edge_sel_i),
  .filt_en_i (filt_en_i),
  .flag_clr_i(flag_clr_i),
  .cap_fire  (cap_fire),
  .cap_val_o (cap_val_o),
  .cap_flag_o(cap_flag_o)
);

// File: tb/tb_icap_unit.sv
module tb_icap_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt = 16'h1200;
  logic        pin = 1'b0, cmp = 1'b0;
  logic        src = 1'b0, pol = 1'b1, filt = 1'b0, clr = 1'b0;
  logic [15:0] cap_val;
  logic        cap_flag;
  int          checks = 0, errors = 0;
  logic [15:0] c, held;

  always #2.5 clk = ~clk;
  always @(posedge clk) cnt <= cnt + 16'd1;

  icap_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .count_i(cnt), .cap_pin_i(pin), .cmp_i(cmp),
    .src_sel_i(src), .edge_sel_i(pol), .filt_en_i(filt), .flag_clr_i(clr),
    .cap_val_o(cap_val), .cap_flag_o(cap_flag)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_flag();
    clr = 1'b1;
    cyc(1);
    clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 reset value", cap_val, 16'h0);
    chk("R1 reset flag", {15'b0, cap_flag}, 16'h0);
  endtask

  task automatic t_rise();
    pin = 1'b1; c = cnt;
    cyc(2);
    chk("R2 no early flag", {15'b0, cap_flag}, 16'h0);
    cyc(1);
    chk("R2 captured value", cap_val, c + 16'd2);
    chk("R7 flag set", {15'b0, cap_flag}, 16'h1);
  endtask

  task automatic t_clear();
    cyc(5);
    chk("R7 flag sticky", {15'b0, cap_flag}, 16'h1);
    clear_flag();
    chk("R7 flag cleared", {15'b0, cap_flag}, 16'h0);
  endtask

  task automatic t_fall();
    held = cap_val;
    pin = 1'b0;
    cyc(6);
    chk("R3 falling ignored flag", {15'b0, cap_flag}, 16'h0);
    chk("R3 falling ignored value", cap_val, held);
    pol = 1'b0;
    cyc(5);
    chk("R9 polarity switch quiet", {15'b0, cap_flag}, 16'h0);
    pin = 1'b1;
    cyc(6);
    chk("R3 rising ignored when falling selected", {15'b0, cap_flag}, 16'h0);
    pin = 1'b0; c = cnt;
    cyc(3);
    chk("R3 falling capture", cap_val, c + 16'd2);
    clear_flag();
  endtask

  task automatic t_overwrite();
    pin = 1'b1; cyc(6);
    pin = 1'b0; cyc(6);
    chk("R8 first capture flag", {15'b0, cap_flag}, 16'h1);
    pin = 1'b1; cyc(6);
    pin = 1'b0; c = cnt;
    cyc(3);
    chk("R8 overwrite while flagged", cap_val, c + 16'd2);
    clear_flag();
    pol = 1'b1;
    cyc(4);
  endtask

  task automatic t_filter();
    filt = 1'b1;
    cyc(4);
    chk("R9 enabling canceler quiet", {15'b0, cap_flag}, 16'h0);
    pin = 1'b1; c = cnt;
    cyc(6);
    chk("R5 no flag before window fills", {15'b0, cap_flag}, 16'h0);
    cyc(1);
    chk("R5 filtered capture value", cap_val, c + 16'd6);
    clear_flag();
    pin = 1'b0;
    cyc(10);
    held = cap_val;
    pin = 1'b1; cyc(3);
    pin = 1'b0; cyc(12);
    chk("R6 short pulse rejected flag", {15'b0, cap_flag}, 16'h0);
    chk("R6 short pulse rejected value", cap_val, held);
    filt = 1'b0;
    cyc(4);
  endtask

  task automatic t_source();
    src = 1'b1;
    cyc(4);
    held = cap_val;
    pin = 1'b1;
    cyc(6);
    chk("R4 pin ignored when comparator selected", {15'b0, cap_flag}, 16'h0);
    cmp = 1'b1; c = cnt;
    cyc(3);
    chk("R4 comparator capture", cap_val, c + 16'd2);
    clear_flag();
  endtask

  task automatic t_cfg_switch();
    cmp = 1'b0;
    cyc(6);
    held = cap_val;
    src = 1'b0;
    cyc(8);
    chk("R9 source switch to high pin quiet", {15'b0, cap_flag}, 16'h0);
    chk("R9 source switch keeps value", cap_val, held);
  endtask

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1'b1;
    cyc(4);
    t_rise();
    t_clear();
    t_fall();
    t_overwrite();
    t_filter();
    t_source();
    t_cfg_switch();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule